// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-page to physical-frame mappings. Each lookup compares the page-number part of a virtual address with the tag of every valid entry at once. On a hit it returns a physical address: the stored frame number sits above the page offset, which passes through unchanged. The result is registered, so it appears one clock after the request.

On a miss, the block reacts according to a mode input. In software-managed mode it raises an exception, and the operating system later installs the mapping through the refill port. In hardware-managed mode it issues a walk request carrying the missing page number to an external table walker. It raises a fault only if that walker reports that no valid mapping exists. A successful walker writes its result through the same refill port.

Refill writes the lowest-indexed invalid entry. When every entry is valid, it overwrites the entry chosen by a round-robin pointer. A flush input empties the whole buffer in one cycle, for use when the active address space changes.

Top module: `tlb_xlat`

## Requirements
- R1: While reset is low and on the first cycle after it is released, all result, walk and fault outputs are 0 and every entry is invalid.
- R2: A lookup sampled with `lk_valid` high produces `rs_valid` high on the following cycle. `rs_hit` is then set if any valid entry's tag equals the address bits above the offset, and `rs_miss` is set otherwise.
- R3: On a hit, `rs_paddr` equals the matching frame number concatenated above the low `OFF_W` bits of the looked-up address.
- R4: With `hw_mode` = 0 at the lookup, a miss sets `rs_exc` together with `rs_miss` and leaves `walk_req` at 0.
- R5: With `hw_mode` = 1 at the lookup, a miss sets `walk_req` with `walk_vpn` equal to the missing page number, and `rs_exc` stays 0.
- R6: `walk_fault` pulses one cycle after `walk_done` = 1 with `walk_ok` = 0 while `hw_mode` = 1. A successful walk does not raise it, and neither does any walk report in software mode.
- R7: A refill writes the lowest-indexed invalid entry when at least one entry is invalid.
- R8: With all entries valid, a refill overwrites the entry at the round-robin pointer. The pointer starts at 0 after reset, advances by one (wrapping at `ENTRIES`) after each such overwrite, and is left unchanged by a flush.
- R9: A flush invalidates every entry in one cycle. A refill presented in the same cycle as a flush is discarded.
- R10: A lookup in the same cycle as a refill or a flush is resolved against the contents held before that clock edge.
- R11: If more than one valid entry matches, the lowest-indexed one supplies the frame and `rs_multi` is set alongside `rs_hit`.
- R12: On a cycle after one with `lk_valid` low, `rs_valid`, `rs_hit`, `rs_miss`, `rs_exc`, `rs_multi` and `walk_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_mode | input | 1 | 0 = software-managed misses, 1 = hardware-managed misses |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | VPN_W | Page number of the new mapping |
| fill_pfn | input | PFN_W | Frame number of the new mapping |
| flush | input | 1 | Invalidate all entries |
| walk_done | input | 1 | Walker finished |
| walk_ok | input | 1 | Walker found a valid mapping |
| rs_valid | output | 1 | Registered lookup result present |
| rs_hit | output | 1 | Lookup hit |
| rs_miss | output | 1 | Lookup missed |
| rs_exc | output | 1 | Miss exception (software mode) |
| rs_multi | output | 1 | More than one entry matched |
| rs_paddr | output | PFN_W+OFF_W | Translated physical address |
| walk_req | output | 1 | Start a table walk (hardware mode) |
| walk_vpn | output | VPN_W | Page number to walk |
| walk_fault | output | 1 | Walk failed, fault raised |

## Verification
A lookup can share a cycle with a refill that evicts the very entry being searched, or with a flush. The bench provokes both by driving the refill or flush together with a lookup of a page that is currently cached. It expects a hit with the old frame, followed on the next lookup by a miss. A flush paired with a refill is judged the same way: a later lookup of the refilled page must miss. Every output is compared each clock against a behavioural model that applies lookups before updates.

// File: rtl/tlb_pkg.sv
// Package: shared types of the translation buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package tlb_pkg;
    typedef enum logic {
        MISS_SW = 1'b0,
        MISS_HW = 1'b1
    } miss_mode_e;

    typedef struct packed {
        logic valid;
        logic hit;
        logic miss;
        logic exc;
        logic multi;
        logic walk;
        logic fault;
    } xlat_flags_t;
endpackage

// File: rtl/tlb_cam.sv
// Entry store with parallel tag compare and lowest-index priority select.
// Assumes: ENTRIES >= 2; write and flush never coincide (caller masks).
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [PFN_W-1:0]           wr_pfn,
    input  logic [VPN_W-1:0]           look_vpn,
    output logic [ENTRIES-1:0]         valid_vec,
    output logic                       match_any,
    output logic                       match_multi,
    output logic [PFN_W-1:0]           match_pfn
);
    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               found;

    // Valid bits: cleared by reset or flush, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and frame storage, written on refill.
    always_ff @(posedge clk) begin
        if (wr_en && !flush) begin
            tag_q[wr_idx] <= wr_vpn;
            pfn_q[wr_idx] <= wr_pfn;
        end
    end

    // One comparator per entry, all active in the same cycle.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (tag_q[g] == look_vpn);
    end

    // Lowest-indexed matching entry supplies the frame.
    always_comb begin
        match_pfn = '0;
        found     = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i] && !found) begin
                match_pfn = pfn_q[i];
                found     = 1'b1;
            end
        end
    end

    assign match_any   = |hit_vec;
    assign match_multi = ($countones(hit_vec) > 1);
    assign valid_vec   = vld_q;

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
    // R7
    write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/tlb_victim.sv
// Picks the entry a refill overwrites: lowest invalid, else round-robin.
// Assumes: ENTRIES >= 2; fill_en already excludes flush cycles.
module tlb_victim #(
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ENTRIES-1:0]         valid_vec,
    input  logic                       fill_en,
    output logic [$clog2(ENTRIES)-1:0] fill_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;
    logic             full;

    // Lowest-indexed invalid entry.
    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec[i] && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
    end

    assign full     = &valid_vec;
    assign fill_idx = full ? rr_q : free_idx;

    // Round-robin pointer advances only on an overwrite of a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_en && full) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R7
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !full) |-> !valid_vec[fill_idx]);
    // R8
    rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rr_q <= IDX_W'(ENTRIES - 1));
endmodule

// File: rtl/tlb_xlat.sv
// Top: registered lookup result, miss handling per mode, refill and flush.
// Assumes: walker refills through fill_*; hw_mode is sampled with each event.
module tlb_xlat #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hw_mode,
    input  logic                     lk_valid,
    input  logic [VPN_W+OFF_W-1:0]   lk_vaddr,
    input  logic                     fill_valid,
    input  logic [VPN_W-1:0]         fill_vpn,
    input  logic [PFN_W-1:0]         fill_pfn,
    input  logic                     flush,
    input  logic                     walk_done,
    input  logic                     walk_ok,
    output logic                     rs_valid,
    output logic                     rs_hit,
    output logic                     rs_miss,
    output logic                     rs_exc,
    output logic                     rs_multi,
    output logic [PFN_W+OFF_W-1:0]   rs_paddr,
    output logic                     walk_req,
    output logic [VPN_W-1:0]         walk_vpn,
    output logic                     walk_fault
);
    import tlb_pkg::*;

    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]   look_vpn;
    logic [OFF_W-1:0]   look_off;
    logic [ENTRIES-1:0] valid_vec;
    logic               match_any, match_multi;
    logic [PFN_W-1:0]   match_pfn;
    logic               fill_en;
    logic [IDX_W-1:0]   fill_idx;
    miss_mode_e         mode;
    xlat_flags_t        flags_d, flags_q;
    logic [PA_W-1:0]    paddr_q;
    logic [VPN_W-1:0]   wvpn_q;

    assign look_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign look_off = lk_vaddr[OFF_W-1:0];
    assign fill_en  = fill_valid && !flush;
    assign mode     = miss_mode_e'(hw_mode);

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) cam_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(fill_en), .wr_idx(fill_idx), .wr_vpn(fill_vpn), .wr_pfn(fill_pfn),
        .look_vpn(look_vpn), .valid_vec(valid_vec),
        .match_any(match_any), .match_multi(match_multi), .match_pfn(match_pfn)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
        .fill_en(fill_en), .fill_idx(fill_idx)
    );

    // Next-cycle result flags from the compare and the miss mode.
    always_comb begin
        flags_d.valid = lk_valid;
        flags_d.hit   = lk_valid && match_any;
        flags_d.miss  = lk_valid && !match_any;
        flags_d.exc   = lk_valid && !match_any && (mode == MISS_SW);
        flags_d.walk  = lk_valid && !match_any && (mode == MISS_HW);
        flags_d.multi = lk_valid && match_multi;
        flags_d.fault = walk_done && !walk_ok && (mode == MISS_HW);
    end

    // Result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            paddr_q <= '0;
            wvpn_q  <= '0;
        end else begin
            flags_q <= flags_d;
            paddr_q <= flags_d.hit ? {match_pfn, look_off} : '0;
            if (flags_d.walk) begin
                wvpn_q <= look_vpn;
            end
        end
    end

    assign rs_valid   = flags_q.valid;
    assign rs_hit     = flags_q.hit;
    assign rs_miss    = flags_q.miss;
    assign rs_exc     = flags_q.exc;
    assign rs_multi   = flags_q.multi;
    assign walk_req   = flags_q.walk;
    assign walk_fault = flags_q.fault;
    assign rs_paddr   = paddr_q;
    assign walk_vpn   = wvpn_q;

    // R2
    hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_hit != rs_miss));
    // R4
    exc_on_sw_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_exc |-> (rs_miss && !walk_req && !$past(hw_mode)));
    // R5
    walk_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (rs_miss && !rs_exc && $past(hw_mode)));
    // R6
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_fault |-> $past(walk_done && !walk_ok && hw_mode));
    // R11
    multi_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_multi |-> rs_hit);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> !(rs_hit || rs_miss || rs_exc || rs_multi || walk_req));
endmodule

// File: tb/tlb_xlat_tb.sv
module tlb_xlat_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int VW  = 8;
    localparam int PW  = 8;
    localparam int OW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_mode = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW+OW-1:0] lk_vaddr = '0;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic          flush = 1'b0;
    logic          walk_done = 1'b0;
    logic          walk_ok = 1'b0;
    logic          rs_valid, rs_hit, rs_miss, rs_exc, rs_multi, walk_req, walk_fault;
    logic [PW+OW-1:0] rs_paddr;
    logic [VW-1:0] walk_vpn;

    int tests = 0;
    int fails = 0;

    // Behavioural reference state.
    bit     m_vld [N];
    int     m_vpn [N];
    int     m_pfn [N];
    int     m_rr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlat #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .OFF_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .flush(flush), .walk_done(walk_done), .walk_ok(walk_ok),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_exc(rs_exc),
        .rs_multi(rs_multi), .rs_paddr(rs_paddr), .walk_req(walk_req),
        .walk_vpn(walk_vpn), .walk_fault(walk_fault)
    );

    // One clock: drive, predict, update model, clock, compare.
    task automatic cyc(input string tag, input bit lk, input int va,
                       input bit fl, input int fv, input int fp,
                       input bit fs, input bit wd, input bit wk);
        int vpn, off, cnt, pfn, vic;
        bit e_hit, e_miss, e_exc, e_walk, e_multi, e_fault;
        int e_paddr;
        bit bad;
        lk_valid = lk; lk_vaddr = (VW+OW)'(va);
        fill_valid = fl; fill_vpn = VW'(fv); fill_pfn = PW'(fp);
        flush = fs; walk_done = wd; walk_ok = wk;
        vpn = (va >> OW) & ((1 << VW) - 1);
        off = va & ((1 << OW) - 1);
        cnt = 0; pfn = 0;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && m_vpn[i] == vpn) begin
                if (cnt == 0) pfn = m_pfn[i];
                cnt++;
            end
        end
        e_hit   = lk && cnt > 0;
        e_miss  = lk && cnt == 0;
        e_exc   = e_miss && !hw_mode;
        e_walk  = e_miss && hw_mode;
        e_multi = lk && cnt > 1;
        e_fault = wd && !wk && hw_mode;
        e_paddr = (pfn << OW) | off;
        if (fs) begin
            for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        end else if (fl) begin
            vic = -1;
            for (int i = 0; i < N; i++) if (!m_vld[i] && vic < 0) vic = i;
            if (vic < 0) begin
                vic = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_vld[vic] = 1'b1; m_vpn[vic] = fv; m_pfn[vic] = fp;
        end
        @(posedge clk);
        #1;
        tests++;
        bad = (rs_valid !== lk) || (rs_hit !== e_hit) || (rs_miss !== e_miss) ||
              (rs_exc !== e_exc) || (rs_multi !== e_multi) ||
              (walk_req !== e_walk) || (walk_fault !== e_fault) ||
              (e_hit && rs_paddr !== (PW+OW)'(e_paddr)) ||
              (e_walk && walk_vpn !== VW'(vpn));
        if (bad) begin
            fails++;
            $display("FAIL %s: got v%b h%b m%b x%b mu%b w%b f%b pa=%h wv=%h exp v%b h%b m%b x%b mu%b w%b f%b pa=%h wv=%h",
                     tag, rs_valid, rs_hit, rs_miss, rs_exc, rs_multi, walk_req, walk_fault,
                     rs_paddr, walk_vpn, lk, e_hit, e_miss, e_exc, e_multi, e_walk,
                     e_fault, e_paddr[PW+OW-1:0], vpn[VW-1:0]);
        end
    endtask

    task automatic look(input string tag, input int va);
        cyc(tag, 1'b1, va, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic fill(input string tag, input int v, input int p);
        cyc(tag, 1'b0, 0, 1'b1, v, p, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        tests++;
        if (rs_valid || rs_hit || rs_miss || rs_exc || rs_multi || walk_req || walk_fault) begin
            fails++;
            $display("FAIL R1: got outputs active during reset expected all 0");
        end
        @(negedge clk);
        rst_n = 1'b1;
        cyc("R1", 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
        look("R4", 12'h123);                 // software miss -> exception
        fill("R7", 8'h10, 8'hA0);
        fill("R7", 8'h11, 8'hA1);
        fill("R7", 8'h12, 8'hA2);
        fill("R7", 8'h13, 8'hA3);
        look("R3", 12'h115);                 // paddr A15
        look("R2", 12'h13F);
        cyc("R12", 1'b0, 12'h110, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
        // Lookup of entry 0 while a refill evicts it.
        cyc("R10", 1'b1, 12'h107, 1'b1, 8'h20, 8'hB0, 1'b0, 1'b0, 1'b0);
        look("R8", 12'h107);                 // now gone
        look("R8", 12'h201);
        fill("R8", 8'h21, 8'hB1);            // overwrites entry 1
        look("R8", 12'h110);
        hw_mode = 1'b1;
        look("R5", 12'h30C);                 // walk request
        cyc("R6", 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b1, 1'b0);
        cyc("R6", 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b1, 1'b1);
        fill("R8", 8'h30, 8'hC0);            // walker refill, entry 2
        look("R5", 12'h30C);
        // Flush with a lookup in the same cycle.
        cyc("R10", 1'b1, 12'h30C, 1'b0, 0, 0, 1'b1, 1'b0, 1'b0);
        look("R9", 12'h30C);
        cyc("R9", 1'b0, 0, 1'b1, 8'h55, 8'hD5, 1'b1, 1'b0, 1'b0);
        look("R9", 12'h550);
        fill("R11", 8'h40, 8'h01);
        fill("R11", 8'h40, 8'h02);
        look("R11", 12'h40A);                // lowest index wins
        fill("R7", 8'h41, 8'h03);
        fill("R7", 8'h42, 8'h04);
        fill("R8", 8'h43, 8'h05);            // pointer held at 3 across flush
        look("R8", 12'h420);
        look("R11", 12'h401);
        fill("R8", 8'h44, 8'h06);            // pointer wraps to 0
        look("R8", 12'h402);
        hw_mode = 1'b0;
        cyc("R6", 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b1, 1'b0);
        look("R4", 12'h990);
        cyc("R12", 1'b0, 0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule